// File: doc/BRIEF.md
# Gain Range and Power Sequencer

This block sits beside a sampling converter. It owns the converter's two range-select pins, its nap control and its active-low sleep control. Software or a controller asks for one of four gain settings (0, -3, -6 or -9 dB) and raises or lowers level requests for nap and sleep. The sequencer drives the pins and then keeps conversions blocked for as long as the analog side needs to settle or wake up. The wait depends on the kind of transition. Rising from -3 dB to 0 dB is short. Falling from 0 dB to -3 dB is longer, because the reference discharges slowly. Any move into or out of -6 dB or -9 dB is the longest, because an intermediate reference node has to settle first. Waking from sleep and waking from nap each have their own wait.

All waits are parameters counted in clock cycles, and one shared down-counter times them. A `conv_req` pulse passes to `conv_start` only while `ready` is high. Gain requests are single-cycle strobes with no back-pressure: the block always accepts them into a one-entry pending slot, and a later strobe replaces an earlier one that has not yet been applied. Power requests are plain levels. Nothing is applied while a wait is running. When the counter reaches zero, the sequencer acts on the highest-priority outstanding request in this order: sleep entry, sleep exit, nap entry, nap exit, gain change.

Top module: `range_power_seq`

## Requirements
- R1: Gain code g on `gain_req_code` (0 = 0 dB, 1 = -3 dB, 2 = -6 dB, 3 = -9 dB) drives `sel_pins` = ~g, so 0 dB gives 11, -3 dB gives 10, -6 dB gives 01 and -9 dB gives 00.
- R2: While reset is held, `sel_pins` is 11, `nap_pin` is 0, `sleep_n` is 1, `busy` is 1 and `ready` is 0. After reset is released, `ready` stays low for exactly WAIT_SLEEP cycles.
- R3: A gain step from code 1 to code 0 holds `ready` low for WAIT_UP cycles. A step from code 0 to code 1 holds it low for WAIT_DOWN cycles.
- R4: Any gain change whose old or new code is 2 or 3 holds `ready` low for WAIT_DEEP cycles.
- R5: A request for the code that is already selected changes no pin and causes no wait.
- R6: A gain strobe sampled on a clock edge while the block is idle changes `sel_pins` on the next edge. A strobe that arrives during a wait is held, and `sel_pins` does not change until the wait has ended. The most recent held strobe is the one applied.
- R7: Raising `nap_req` while active sets `nap_pin` to 1 one edge later, with `ready` low and `busy` low. Lowering it clears `nap_pin` and holds `ready` low for WAIT_NAP cycles.
- R8: Raising `sleep_req` drives `sleep_n` to 0 and `nap_pin` to 0, even when `nap_req` is also high. Lowering `sleep_req` releases `sleep_n` and keeps `busy` high for WAIT_SLEEP cycles. If `nap_req` is still high at that point, the block wakes into nap.
- R9: A gain request made during sleep leaves `sel_pins` unchanged until wake. It is applied on wake, and the wait is the larger of WAIT_SLEEP and that gain change's own wait.
- R10: `busy` is high exactly while a wait is counting. `conv_start` is high only when `conv_req` is high and `ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gain_req_valid | input | 1 | Single-cycle strobe that requests a gain code |
| gain_req_code | input | 2 | Requested gain code (0 to 3) |
| nap_req | input | 1 | Level request for nap |
| sleep_req | input | 1 | Level request for sleep (takes priority over nap) |
| conv_req | input | 1 | Conversion start request |
| sel_pins | output | 2 | Range-select pins to the converter |
| nap_pin | output | 1 | Nap control, high while in nap |
| sleep_n | output | 1 | Sleep control, low while asleep |
| conv_start | output | 1 | Gated conversion start |
| ready | output | 1 | Active state with no wait in progress |
| busy | output | 1 | A settling or wake-up wait is counting |

## Verification
A corrupted wait count shows up at the ports as a `ready` low window that is longer or shorter than expected. The bench therefore measures every window cycle by cycle, across all sixteen from/to gain pairs and every power transition. A wrong pending slot or a wrong mode register shows up at once, on the next edge, as a wrong value on `sel_pins`, `nap_pin` or `sleep_n`. A gating fault shows up as a `conv_start` pulse inside a low window, because `conv_req` is held high for the whole run.

// File: rtl/rps_pkg.sv
package rps_pkg;
  typedef logic [1:0] gain_t;

  typedef enum logic [1:0] {
    PM_ACTIVE = 2'd0,
    PM_NAP    = 2'd1,
    PM_SLEEP  = 2'd2
  } pmode_t;

  typedef enum logic [2:0] {
    ACT_NONE      = 3'd0,
    ACT_SLEEP_IN  = 3'd1,
    ACT_SLEEP_OUT = 3'd2,
    ACT_NAP_IN    = 3'd3,
    ACT_NAP_OUT   = 3'd4,
    ACT_GAIN      = 3'd5
  } action_t;

  // Pin level is the bitwise inverse of the gain code.
  function automatic logic [1:0] gain_to_pins(input gain_t g);
    return ~g;
  endfunction
endpackage

// File: rtl/rps_wait_sel.sv
module rps_wait_sel
  import rps_pkg::*;
#(
  parameter int CW = 8,
  parameter int unsigned WAIT_UP = 1,
  parameter int unsigned WAIT_DOWN = 1,
  parameter int unsigned WAIT_DEEP = 1
) (
  input  gain_t         from_g,
  input  gain_t         to_g,
  output logic [CW-1:0] wait_cyc
);
  localparam logic [CW-1:0] W_UP   = CW'(WAIT_UP);
  localparam logic [CW-1:0] W_DOWN = CW'(WAIT_DOWN);
  localparam logic [CW-1:0] W_DEEP = CW'(WAIT_DEEP);

  always_comb begin
    if (from_g == to_g)               wait_cyc = '0;
    else if (from_g[1] || to_g[1])    wait_cyc = W_DEEP;
    else if (to_g == 2'd0)            wait_cyc = W_UP;
    else                              wait_cyc = W_DOWN;
  end
endmodule

// File: rtl/rps_countdown.sv
module rps_countdown #(
  parameter int CW = 8,
  parameter logic [CW-1:0] INIT = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= INIT;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  assert_load_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> zero);

  assert_count_down_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!zero && !load) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/rps_gain_track.sv
module rps_gain_track
  import rps_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_valid,
  input  gain_t req_code,
  input  logic  apply,
  output gain_t cur,
  output gain_t pend,
  output logic  pend_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur        <= 2'd0;
      pend       <= 2'd0;
      pend_valid <= 1'b0;
    end else begin
      if (apply) cur <= pend;
      if (req_valid) begin
        pend       <= req_code;
        pend_valid <= 1'b1;
      end else if (apply) begin
        pend_valid <= 1'b0;
      end
    end
  end

  assert_pend_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid && !apply) |=> pend_valid);

  assert_apply_has_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    apply |-> pend_valid);
endmodule

// File: rtl/range_power_seq.sv
module range_power_seq
  import rps_pkg::*;
#(
  parameter int unsigned WAIT_UP    = 120000,
  parameter int unsigned WAIT_DOWN  = 2200000,
  parameter int unsigned WAIT_DEEP  = 140000000,
  parameter int unsigned WAIT_SLEEP = 42000000,
  parameter int unsigned WAIT_NAP   = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gain_req_valid,
  input  logic [1:0] gain_req_code,
  input  logic       nap_req,
  input  logic       sleep_req,
  input  logic       conv_req,
  output logic [1:0] sel_pins,
  output logic       nap_pin,
  output logic       sleep_n,
  output logic       conv_start,
  output logic       ready,
  output logic       busy
);
  localparam int unsigned M1   = (WAIT_UP > WAIT_DOWN) ? WAIT_UP : WAIT_DOWN;
  localparam int unsigned M2   = (M1 > WAIT_DEEP) ? M1 : WAIT_DEEP;
  localparam int unsigned M3   = (M2 > WAIT_SLEEP) ? M2 : WAIT_SLEEP;
  localparam int unsigned MAXW = (M3 > WAIT_NAP) ? M3 : WAIT_NAP;
  localparam int CW = $clog2(MAXW + 1);
  localparam logic [CW-1:0] W_SLEEP = CW'(WAIT_SLEEP);
  localparam logic [CW-1:0] W_NAP   = CW'(WAIT_NAP);

  pmode_t        mode;
  action_t       act;
  gain_t         cur, pend, to_g;
  logic          pend_valid, cnt_zero, apply, load;
  logic [CW-1:0] gain_w, load_val;

  rps_gain_track u_gain (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (gain_req_valid),
    .req_code   (gain_req_code),
    .apply      (apply),
    .cur        (cur),
    .pend       (pend),
    .pend_valid (pend_valid)
  );

  assign to_g = pend_valid ? pend : cur;

  rps_wait_sel #(
    .CW        (CW),
    .WAIT_UP   (WAIT_UP),
    .WAIT_DOWN (WAIT_DOWN),
    .WAIT_DEEP (WAIT_DEEP)
  ) u_wsel (
    .from_g   (cur),
    .to_g     (to_g),
    .wait_cyc (gain_w)
  );

  // Decision: only when no wait is running; sleep first, then nap, then gain.
  always_comb begin
    act = ACT_NONE;
    if (cnt_zero) begin
      if (sleep_req && mode != PM_SLEEP)       act = ACT_SLEEP_IN;
      else if (mode == PM_SLEEP)               act = sleep_req ? ACT_NONE : ACT_SLEEP_OUT;
      else if (nap_req && mode == PM_ACTIVE)   act = ACT_NAP_IN;
      else if (!nap_req && mode == PM_NAP)     act = ACT_NAP_OUT;
      else if (pend_valid)                     act = ACT_GAIN;
    end
  end

  assign apply = pend_valid && (act == ACT_GAIN || act == ACT_SLEEP_OUT);

  always_comb begin
    load     = 1'b0;
    load_val = '0;
    case (act)
      ACT_SLEEP_OUT: begin
        load     = 1'b1;
        load_val = (gain_w > W_SLEEP) ? gain_w : W_SLEEP;
      end
      ACT_NAP_OUT: begin
        load     = 1'b1;
        load_val = W_NAP;
      end
      ACT_GAIN: begin
        load     = 1'b1;
        load_val = gain_w;
      end
      default: ;
    endcase
  end

  rps_countdown #(
    .CW   (CW),
    .INIT (W_SLEEP)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .zero     (cnt_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= PM_ACTIVE;
    end else begin
      case (act)
        ACT_SLEEP_IN:  mode <= PM_SLEEP;
        ACT_SLEEP_OUT: mode <= nap_req ? PM_NAP : PM_ACTIVE;
        ACT_NAP_IN:    mode <= PM_NAP;
        ACT_NAP_OUT:   mode <= PM_ACTIVE;
        default: ;
      endcase
    end
  end

  assign sel_pins   = gain_to_pins(cur);
  assign nap_pin    = (mode == PM_NAP);
  assign sleep_n    = (mode != PM_SLEEP);
  assign busy       = !cnt_zero;
  assign ready      = cnt_zero && (mode == PM_ACTIVE);
  assign conv_start = conv_req && ready;

  assert_pins_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_pins) |-> $past(cnt_zero));

  assert_change_waits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sel_pins) |-> busy);

  assert_nap_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(nap_pin) && sleep_n) |-> busy);

  assert_wake_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sleep_n) |-> busy);

  assert_sleep_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(nap_pin && !sleep_n));

  assert_sleep_pins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_n && $past(!sleep_n)) |-> $stable(sel_pins));
endmodule

// File: tb/tb_range_power_seq.sv
`timescale 1ns/1ps
module tb_range_power_seq;
  localparam int T_UP = 5, T_DOWN = 9, T_DEEP = 23, T_SLEEP = 17, T_NAP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gv = 1'b0;
  logic [1:0] gc = 2'd0;
  logic nap_req = 1'b0, sleep_req = 1'b0, conv_req = 1'b1;
  logic [1:0] sel_pins;
  logic nap_pin, sleep_n, conv_start, ready, busy;

  int checks = 0, fails = 0;
  int cur_m = 0;

  always #2.5 clk = ~clk;

  range_power_seq #(
    .WAIT_UP(T_UP), .WAIT_DOWN(T_DOWN), .WAIT_DEEP(T_DEEP),
    .WAIT_SLEEP(T_SLEEP), .WAIT_NAP(T_NAP)
  ) dut (
    .clk(clk), .rst_n(rst_n), .gain_req_valid(gv), .gain_req_code(gc),
    .nap_req(nap_req), .sleep_req(sleep_req), .conv_req(conv_req),
    .sel_pins(sel_pins), .nap_pin(nap_pin), .sleep_n(sleep_n),
    .conv_start(conv_start), .ready(ready), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_wait(input int f, input int t);
    if (f == t) return 0;
    if (f >= 2 || t >= 2) return T_DEEP;
    if (f == 1 && t == 0) return T_UP;
    return T_DOWN;
  endfunction

  task automatic count_lows(output int n, output int leak);
    n = 0; leak = 0;
    while (!ready && n < 1000) begin
      if (conv_start) leak++;
      n++;
      @(negedge clk);
    end
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic gain_step(input int code, input string tag);
    int n, leak, e;
    e = exp_wait(cur_m, code);
    @(negedge clk); gv = 1'b1; gc = code[1:0];
    @(negedge clk); gv = 1'b0;
    @(negedge clk);
    check(sel_pins == ~code[1:0], "R1", "sel_pins", sel_pins, 2'(~code[1:0]));
    count_lows(n, leak);
    check(n == e, tag, "ready low cycles", n, e);
    check(leak == 0, "R10", "conv_start in wait", leak, 0);
    cur_m = code;
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "WATCHDOG", "timeout", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n, leak;
    repeat (3) @(negedge clk);
    // R2: reset state
    check(sel_pins == 2'b11, "R2", "reset sel_pins", sel_pins, 3);
    check(nap_pin == 1'b0 && sleep_n == 1'b1, "R2", "reset power pins", {nap_pin, sleep_n}, 1);
    check(busy == 1'b1 && ready == 1'b0, "R2", "reset busy/ready", {busy, ready}, 2);
    rst_n = 1'b1;
    count_lows(n, leak);
    check(n == T_SLEEP, "R2", "wake after reset", n, T_SLEEP);

    // R3/R4/R5: all from/to pairs
    for (int f = 0; f < 4; f++) begin
      for (int t = 0; t < 4; t++) begin
        gain_step(f, "R5_set");
        gain_step(t, (f == t) ? "R5" : ((f >= 2 || t >= 2) ? "R4" : "R3"));
      end
    end

    // R7: nap entry and exit
    @(negedge clk); nap_req = 1'b1;
    @(negedge clk);
    check(nap_pin == 1'b1, "R7", "nap_pin on", nap_pin, 1);
    check(ready == 1'b0 && busy == 1'b0, "R7", "nap ready/busy", {ready, busy}, 0);
    nap_req = 1'b0;
    @(negedge clk);
    check(nap_pin == 1'b0, "R7", "nap_pin off", nap_pin, 0);
    count_lows(n, leak);
    check(n == T_NAP, "R7", "nap wake cycles", n, T_NAP);
    check(leak == 0, "R10", "conv_start in nap wake", leak, 0);

    gain_step(0, "R4");

    // R8/R9: sleep beats nap; gain held during sleep, sleep wait dominates
    @(negedge clk); sleep_req = 1'b1; nap_req = 1'b1;
    @(negedge clk);
    check(sleep_n == 1'b0 && nap_pin == 1'b0, "R8", "sleep over nap", {sleep_n, nap_pin}, 0);
    gv = 1'b1; gc = 2'd1;
    @(negedge clk); gv = 1'b0;
    @(negedge clk);
    check(sel_pins == 2'b11, "R9", "pins held in sleep", sel_pins, 3);
    sleep_req = 1'b0; nap_req = 1'b0;
    @(negedge clk);
    check(sleep_n == 1'b1 && sel_pins == 2'b10, "R9", "wake pins", {sleep_n, sel_pins}, 6);
    count_lows(n, leak);
    check(n == T_SLEEP, "R9", "wake wait sleep-dominated", n, T_SLEEP);
    cur_m = 1;

    // R9: gain wait dominates
    @(negedge clk); sleep_req = 1'b1;
    @(negedge clk); gv = 1'b1; gc = 2'd3;
    @(negedge clk); gv = 1'b0; sleep_req = 1'b0;
    @(negedge clk);
    check(sel_pins == 2'b00, "R9", "wake pins deep", sel_pins, 0);
    count_lows(n, leak);
    check(n == T_DEEP, "R9", "wake wait gain-dominated", n, T_DEEP);
    cur_m = 3;

    // R8: wake from sleep into nap
    @(negedge clk); sleep_req = 1'b1; nap_req = 1'b1;
    @(negedge clk); sleep_req = 1'b0;
    @(negedge clk);
    check(nap_pin == 1'b1 && sleep_n == 1'b1, "R8", "wake into nap", {nap_pin, sleep_n}, 3);
    count_busy(n);
    check(n == T_SLEEP, "R8", "sleep wake busy cycles", n, T_SLEEP);
    check(ready == 1'b0, "R8", "no ready in nap", ready, 0);
    nap_req = 1'b0;
    @(negedge clk);
    count_lows(n, leak);
    check(n == T_NAP, "R7", "nap exit after sleep", n, T_NAP);

    gain_step(0, "R4");

    // R6: pending during wait, latest wins
    @(negedge clk); gv = 1'b1; gc = 2'd1;
    @(negedge clk); gv = 1'b0;
    @(negedge clk);
    check(sel_pins == 2'b10 && busy == 1'b1, "R6", "first step applied", {sel_pins, busy}, 5);
    gv = 1'b1; gc = 2'd3;
    @(negedge clk); gc = 2'd2;
    @(negedge clk); gv = 1'b0;
    check(sel_pins == 2'b10, "R6", "pins held in wait", sel_pins, 2);
    while (!ready) @(negedge clk);
    check(sel_pins == 2'b10, "R6", "pins at wait end", sel_pins, 2);
    @(negedge clk);
    check(sel_pins == 2'b01, "R6", "latest pending applied", sel_pins, 1);
    count_lows(n, leak);
    check(n == T_DEEP, "R6", "pending wait", n, T_DEEP);
    check(conv_start == 1'b1, "R10", "conv_start when ready", conv_start, 1);
    conv_req = 1'b0;
    @(negedge clk);
    check(conv_start == 1'b0, "R10", "conv_start without req", conv_start, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule